// File: doc/BRIEF.md
# Bus Breakpoint Comparator Unit

This block watches the completed cycles of a 68000-style system bus and raises a debug interrupt when a cycle matches a programmed breakpoint. It holds one 32-bit address comparator and one 4-bit bus-control comparator. Each has its own don't-care mask, and each can be switched on or off separately. A cycle counts as a hit only when the unit is enabled, the cycle-complete strobe is high, and every enabled comparator agrees under its mask.

A hit sets a sticky flag. While the flag is set, the unit drives the highest-priority interrupt request, level 7, which is the level kept for an in-circuit debugger. Software clears the flag by writing a one to it. In single mode the first hit turns the unit off, so one breakpoint is caught and no more. In repeat mode the unit stays armed, and a hit counter records every occurrence.

Software programs the unit through a small register port that has a write strobe, a 3-bit word offset, and a combinational read-back of the addressed word.

Top module: `bus_brkpt_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, all registers read back zero, `dbg_irq` is low and `irq_level` is 0.
- R2: Offset 0 holds the address to match and offset 1 holds the address mask, where a 1 in the mask makes that address bit a don't-care. With the address term enabled, a cycle whose unmasked bits differ does not hit.
- R3: Offset 2 holds the control value in bits [3:0] and the control mask in bits [7:4], where a mask 1 means don't-care. The control bits are bit0 read (1) or write (0), bit1 upper byte strobe, bit2 lower byte strobe and bit3 program space (1) or data space (0).
- R4: A hit is evaluated only in a cycle where `bus_done` is high. A matching bus value without `bus_done` has no effect.
- R5: Offset 3 is the configuration word: bit0 master enable, bit1 address term enable, bit2 control term enable, bit3 repeat mode. A disabled term always agrees. An enabled term that disagrees blocks the hit.
- R6: With the master enable at 0, no cycle hits: the flag and the count stay unchanged.
- R7: In single mode (bit3 = 0), a hit clears the master enable on the following edge, and a later matching cycle does not hit.
- R8: In repeat mode the master enable stays set, and the hit count at offset 4 bits [31:16] rises by one for every hit, the cycle after the hit.
- R9: The hit flag at offset 4 bit0 is set the cycle after a hit and stays set. Writing 1 to bit0 at offset 4 clears it. Writing 0 leaves it set.
- R10: `dbg_irq` is high exactly while the flag is set, and `irq_level` then reads 7. Otherwise `irq_level` reads 0.
- R11: A hit and a flag-clear write in the same cycle leave the flag set.
- R12: A configuration write and a single-mode hit in the same cycle leave the configuration equal to the written value, and the hit still sets the flag and increments the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the addressed register |
| bus_done | input | 1 | Bus cycle complete strobe |
| bus_addr | input | 32 | Address of the bus cycle |
| bus_ctrl | input | 4 | Control bits of the bus cycle (see R3) |
| dbg_irq | output | 1 | Debug interrupt request, follows the hit flag |
| irq_level | output | 3 | Requested priority level, 7 while requesting |

## Verification
Two events can land on the same edge: a software write and a hit. The first case is a flag-clear write in the same cycle as a matching completed bus cycle. The second is a configuration write in the same cycle as a single-mode hit. The bench drives both events in one cycle. Its reference model gives the hit precedence over the clear, and gives the write precedence over the single-mode disarm. The outputs and all five register read-backs are then compared against that model on the following cycles.

// File: rtl/bbk_pkg.sv
// Package: shared register offsets, configuration layout and control bit
// positions for the bus breakpoint unit. Assumes a 3-bit word offset.
package bbk_pkg;
    localparam logic [2:0] OFF_AVAL = 3'd0;
    localparam logic [2:0] OFF_AMSK = 3'd1;
    localparam logic [2:0] OFF_CTRL = 3'd2;
    localparam logic [2:0] OFF_CFG  = 3'd3;
    localparam logic [2:0] OFF_STAT = 3'd4;

    // Bus control field positions
    localparam int CB_READ  = 0;
    localparam int CB_UPPER = 1;
    localparam int CB_LOWER = 2;
    localparam int CB_PROG  = 3;

    typedef struct packed {
        logic repeat_md;
        logic ctl_on;
        logic adr_on;
        logic arm;
    } bbk_cfg_t;

    localparam logic [2:0] BRK_LEVEL = 3'd7;
endpackage

// File: rtl/bbk_cmp.sv
// Masked equality comparator. A mask bit of 1 excludes that bit. When the
// term is disabled the comparator always agrees. Purely combinational.
module bbk_cmp #(
    parameter int W = 32
) (
    input  logic         term_on,
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] ref_msk,
    input  logic [W-1:0] seen,
    output logic         agree
);
    // Compare only the bits that are not masked
    always_comb begin
        agree = !term_on || (((seen ^ ref_val) & ~ref_msk) == '0);
    end
endmodule

// File: rtl/bbk_regs.sv
// Register file of the breakpoint unit: match values, masks, configuration,
// sticky hit flag and hit counter. Assumes DATA_W >= 2*CTRL_W and
// DATA_W >= CNT_W + 1. The hit input is the qualified hit of this cycle.
module bbk_regs
    import bbk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        off,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    output logic [ADDR_W-1:0] a_val,
    output logic [ADDR_W-1:0] a_msk,
    output logic [CTRL_W-1:0] c_val,
    output logic [CTRL_W-1:0] c_msk,
    output bbk_cfg_t          cfg,
    output logic              flag,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_LSB = DATA_W - CNT_W;

    logic wr_aval, wr_amsk, wr_ctrl, wr_cfg, clr_flag;

    // Decode the write strobes per register
    always_comb begin
        wr_aval  = wr && (off == OFF_AVAL);
        wr_amsk  = wr && (off == OFF_AMSK);
        wr_ctrl  = wr && (off == OFF_CTRL);
        wr_cfg   = wr && (off == OFF_CFG);
        clr_flag = wr && (off == OFF_STAT) && wdata[0];
    end

    // Match value and mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_val <= '0;
            a_msk <= '0;
            c_val <= '0;
            c_msk <= '0;
        end else begin
            if (wr_aval) a_val <= wdata[ADDR_W-1:0];
            if (wr_amsk) a_msk <= wdata[ADDR_W-1:0];
            if (wr_ctrl) begin
                c_val <= wdata[CTRL_W-1:0];
                c_msk <= wdata[2*CTRL_W-1:CTRL_W];
            end
        end
    end

    // Configuration: a software write wins, otherwise a single-mode hit disarms
    always_ff @(posedge clk) begin
        if (!rst_n)                     cfg <= '0;
        else if (wr_cfg)                cfg <= bbk_cfg_t'(wdata[3:0]);
        else if (hit && !cfg.repeat_md) cfg.arm <= 1'b0;
    end

    // Sticky flag: a hit has priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (clr_flag) flag <= 1'b0;
    end

    // Hit counter, wraps at its width
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (hit) cnt <= cnt + CNT_W'(1);
    end

    // Read-back mux for the addressed word
    always_comb begin
        rdata = '0;
        unique case (off)
            OFF_AVAL: rdata[ADDR_W-1:0] = a_val;
            OFF_AMSK: rdata[ADDR_W-1:0] = a_msk;
            OFF_CTRL: rdata[2*CTRL_W-1:0] = {c_msk, c_val};
            OFF_CFG:  rdata[3:0] = cfg;
            OFF_STAT: begin
                rdata[0] = flag;
                rdata[DATA_W-1:CNT_LSB] = cnt;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/bus_brkpt_unit.sv
// Top of the bus breakpoint unit. It samples each completed bus cycle and
// requires both enabled comparator terms to agree. The hit flag drives the
// level-7 debug request. Assumes bus inputs are stable while bus_done is high.
module bus_brkpt_unit
    import bbk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bus_done,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTRL_W-1:0] bus_ctrl,
    output logic              dbg_irq,
    output logic [2:0]        irq_level
);
    logic [ADDR_W-1:0] a_val, a_msk;
    logic [CTRL_W-1:0] c_val, c_msk;
    bbk_cfg_t          cfg;
    logic              flag;
    logic [CNT_W-1:0]  hit_cnt;
    logic              a_ok, c_ok, hit;
    logic              cfg_arm, cfg_rep;

    bbk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .off(reg_addr), .wdata(reg_wdata),
        .hit(hit), .a_val(a_val), .a_msk(a_msk), .c_val(c_val), .c_msk(c_msk),
        .cfg(cfg), .flag(flag), .cnt(hit_cnt), .rdata(reg_rdata)
    );

    bbk_cmp #(.W(ADDR_W)) u_acmp (
        .term_on(cfg.adr_on), .ref_val(a_val), .ref_msk(a_msk), .seen(bus_addr), .agree(a_ok)
    );

    bbk_cmp #(.W(CTRL_W)) u_ccmp (
        .term_on(cfg.ctl_on), .ref_val(c_val), .ref_msk(c_msk), .seen(bus_ctrl), .agree(c_ok)
    );

    // Qualify the hit and drive the request outputs
    always_comb begin
        cfg_arm   = cfg.arm;
        cfg_rep   = cfg.repeat_md;
        hit       = cfg_arm && bus_done && a_ok && c_ok;
        dbg_irq   = flag;
        irq_level = flag ? BRK_LEVEL : 3'd0;
    end
endmodule

// File: rtl/bbk_checker.sv
// Property checker for the bus breakpoint unit, attached by bind.
// Assumes it sees the top's internal hit, enable, mode and count signals.
module bbk_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic             wbit0,
    input logic             bus_done,
    input logic             hit,
    input logic             cfg_arm,
    input logic             cfg_rep,
    input logic [CNT_W-1:0] hit_cnt,
    input logic             dbg_irq,
    input logic [2:0]       irq_level
);
    assert_level_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq |-> irq_level == 3'd7);
    assert_level_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_irq |-> irq_level == 3'd0);
    assert_rise_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_irq) |-> $past(bus_done));
    assert_off_count_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_arm |=> $stable(hit_cnt));
    assert_single_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cfg_rep && !(reg_wr && reg_addr == 3'd3)) |=> !cfg_arm);
    assert_repeat_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cfg_rep && !(reg_wr && reg_addr == 3'd3)) |=> cfg_arm);
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> hit_cnt == $past(hit_cnt) + CNT_W'(1));
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_irq && !(reg_wr && reg_addr == 3'd4 && wbit0)) |=> dbg_irq);
    assert_hit_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> dbg_irq);
endmodule

bind bus_brkpt_unit bbk_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .wbit0(reg_wdata[0]),
    .bus_done(bus_done), .hit(hit), .cfg_arm(cfg_arm), .cfg_rep(cfg_rep),
    .hit_cnt(hit_cnt), .dbg_irq(dbg_irq), .irq_level(irq_level)
);

// File: tb/bus_brkpt_unit_bench.sv
// Bench: a behavioural reference model updated on each edge and compared
// against the outputs and the addressed register on every cycle.
module bus_brkpt_unit_bench;
    localparam int CYC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        bus_done = 1'b0;
    logic [31:0] bus_addr = 32'd0;
    logic [3:0]  bus_ctrl = 4'd0;
    logic        dbg_irq;
    logic [2:0]  irq_level;

    int n_cmp = 0;
    int n_bad = 0;
    string cur = "R1";

    // reference model state
    bit [31:0] m_aval, m_amsk;
    bit [7:0]  m_ctrl;
    bit [3:0]  m_cfg;
    bit        m_flag;
    int unsigned m_cnt;

    always #(CYC/2) clk = ~clk;

    bus_brkpt_unit u_bus_brkpt_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_done(bus_done),
        .bus_addr(bus_addr), .bus_ctrl(bus_ctrl), .dbg_irq(dbg_irq), .irq_level(irq_level)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_rd(input bit [2:0] a);
        case (a)
            3'd0: return m_aval;
            3'd1: return m_amsk;
            3'd2: return {24'd0, m_ctrl};
            3'd3: return {28'd0, m_cfg};
            3'd4: return {m_cnt[15:0], 15'd0, m_flag};
            default: return 32'd0;
        endcase
    endfunction

    // compare the request outputs and the addressed word
    task automatic compare_now();
        check(cur, "dbg_irq", {31'd0, dbg_irq}, {31'd0, m_flag});
        check(cur, "irq_level", {29'd0, irq_level}, m_flag ? 32'd7 : 32'd0);
        check(cur, "rdata", reg_rdata, exp_rd(reg_addr));
    endtask

    // read every register at the ports
    task automatic read_all();
        for (int a = 0; a < 5; a++) begin
            reg_addr = 3'(a);
            #1;
            check(cur, "readback", reg_rdata, exp_rd(3'(a)));
        end
    endtask

    // one clock: drive, update the model at the edge, compare after it
    task automatic cyc(input bit wr, input bit [2:0] a, input bit [31:0] wd,
                       input bit done, input bit [31:0] ba, input bit [3:0] bc);
        bit hit, aok, cok;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        bus_done = done; bus_addr = ba; bus_ctrl = bc;
        @(posedge clk);
        aok = !m_cfg[1] || (((ba ^ m_aval) & ~m_amsk) == 0);
        cok = !m_cfg[2] || (((bc ^ m_ctrl[3:0]) & ~m_ctrl[7:4]) == 0);
        hit = m_cfg[0] && done && aok && cok;
        if (wr && a == 3'd0) m_aval = wd;
        if (wr && a == 3'd1) m_amsk = wd;
        if (wr && a == 3'd2) m_ctrl = wd[7:0];
        if (wr && a == 3'd3) m_cfg = wd[3:0];
        else if (hit && !m_cfg[3]) m_cfg[0] = 1'b0;
        if (hit) m_flag = 1'b1;
        else if (wr && a == 3'd4 && wd[0]) m_flag = 1'b0;
        if (hit) m_cnt = m_cnt + 1;
        @(negedge clk);
        compare_now();
        reg_wr = 1'b0; bus_done = 1'b0;
    endtask

    task automatic wreg(input bit [2:0] a, input bit [31:0] d);
        cyc(1'b1, a, d, 1'b0, 32'd0, 4'd0);
    endtask

    task automatic bus(input bit [31:0] ba, input bit [3:0] bc);
        cyc(1'b0, 3'd4, 32'd0, 1'b1, ba, bc);
    endtask

    // watchdog
    initial begin
        #(CYC * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_aval = 0; m_amsk = 0; m_ctrl = 0; m_cfg = 0; m_flag = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur = "R1"; read_all(); compare_now();
        rst_n = 1'b1;
        @(negedge clk);
        read_all(); compare_now();

        // R2: masked address match, low byte don't-care
        cur = "R2";
        wreg(3'd0, 32'h0010_2000);
        wreg(3'd1, 32'h0000_00FF);
        wreg(3'd3, 32'h0000_000B);
        bus(32'h0010_20AB, 4'h0);
        check("R2", "flag after masked hit", {31'd0, dbg_irq}, 32'd1);
        wreg(3'd4, 32'h1);
        bus(32'h0010_2100, 4'h0);
        check("R2", "no hit on unmasked diff", {31'd0, dbg_irq}, 32'd0);

        // R4: matching values without the cycle strobe
        cur = "R4";
        cyc(1'b0, 3'd4, 32'd0, 1'b0, 32'h0010_2000, 4'h0);
        check("R4", "no hit without bus_done", {31'd0, dbg_irq}, 32'd0);

        // R3: control match, program-space bit don't-care
        cur = "R3";
        wreg(3'd2, 32'h0000_0085);
        wreg(3'd3, 32'h0000_000D);
        bus(32'hFFFF_0000, 4'b1101);
        wreg(3'd4, 32'h1);
        bus(32'hFFFF_0000, 4'b0111);
        read_all();

        // R5: both terms enabled, each must agree
        cur = "R5";
        wreg(3'd3, 32'h0000_000F);
        bus(32'h0010_2033, 4'b0011);
        check("R5", "ctrl disagree blocks", {31'd0, dbg_irq}, 32'd0);
        bus(32'h0011_2033, 4'b0101);
        bus(32'h0010_2033, 4'b0101);
        check("R5", "both agree hit", {31'd0, dbg_irq}, 32'd1);
        wreg(3'd4, 32'h1);

        // R6: master enable off
        cur = "R6";
        wreg(3'd3, 32'h0000_000E);
        bus(32'h0010_2033, 4'b0101);
        bus(32'h0010_2000, 4'b0101);
        read_all();

        // R7: single mode disarms after first hit
        cur = "R7";
        wreg(3'd3, 32'h0000_0003);
        bus(32'h0010_2044, 4'h0);
        reg_addr = 3'd3; #1;
        check("R7", "arm cleared", reg_rdata, 32'h2);
        wreg(3'd4, 32'h1);
        bus(32'h0010_2044, 4'h0);
        check("R7", "second match ignored", {31'd0, dbg_irq}, 32'd0);

        // R8: repeat mode counts every hit
        cur = "R8";
        wreg(3'd3, 32'h0000_000B);
        for (int i = 0; i < 5; i++) bus(32'h0010_2000 + 32'(i), 4'h0);
        reg_addr = 3'd4; #1;
        check("R8", "count after repeats", reg_rdata[31:16], 32'(m_cnt));
        read_all();

        // R9: write 0 keeps flag, write 1 clears
        cur = "R9";
        wreg(3'd4, 32'h0);
        check("R9", "write 0 keeps", {31'd0, dbg_irq}, 32'd1);
        wreg(3'd4, 32'h1);
        check("R9", "write 1 clears", {31'd0, dbg_irq}, 32'd0);

        // R10: level follows the request
        cur = "R10";
        bus(32'h0010_2001, 4'h0);
        check("R10", "level 7", {29'd0, irq_level}, 32'd7);

        // R11: hit and clear in the same cycle
        cur = "R11";
        cyc(1'b1, 3'd4, 32'h1, 1'b1, 32'h0010_2002, 4'h0);
        check("R11", "hit beats clear", {31'd0, dbg_irq}, 32'd1);
        wreg(3'd4, 32'h1);

        // R12: config write and single-mode hit in the same cycle
        cur = "R12";
        wreg(3'd3, 32'h0000_0003);
        cyc(1'b1, 3'd3, 32'h0000_0003, 1'b1, 32'h0010_2003, 4'h0);
        reg_addr = 3'd3; #1;
        check("R12", "write wins cfg", reg_rdata, 32'h3);
        check("R12", "flag set", {31'd0, dbg_irq}, 32'd1);
        read_all();
        bus(32'h0010_2004, 4'h0);
        read_all();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule